// File: doc/BRIEF.md
# I/O Rail Deep Power-Down Controller

This block holds the deep power-down state of up to 60 I/O rails, split over two groups of 30. Software writes a request word to a group: the low 30 bits pick the rails and the top two bits say what to do with them (leave them alone, bring them out of power-down, or put them into power-down). The block waits a programmed minimum interval, counted in bus clock cycles, before it changes the rail state. This interval gives the pad logic time to sample the request. Requests are acted on only while a global sampling switch is on.

Each group has its own state register, which software can read back. The same state also drives one power-down output line per rail. Once a request has been carried out, the command field of that group goes back to idle, and the group can accept the next request. The register port follows the two-phase APB write/read protocol with no wait states.

Top module: `iorail_dpd_ctrl`

## Requirements
- R1: After reset every rail output is 0 and every register reads 0.
- R2: Register offsets: 0x020 holds the sampling switch in bit 0; 0x1C8 holds the interval count (TMR_W bits, read/write); 0x1B8 and 0x1C0 are the request words of groups 0 and 1; 0x1BC and 0x1C4 are their state words (read-only).
- R3: In a request word, bits 29:0 select rails, and rail n of group g drives output bit 32g+n. Bits 31:30 are the command: 0 = idle, 1 = leave power-down, 2 = enter power-down, 3 = reserved. A reserved command is stored as 0 and has no effect on any rail.
- R4: A state bit is 1 while its rail is in power-down and 0 while it is out. A state word reads as {2'b00, state}. Output bits 31:30 and 63:62 are always 0.
- R5: With sampling on and interval count T≥1, the selected rails change on the (T+1)-th rising edge after the edge that completes the write. A count of 0 is treated as 1.
- R6: Rails that a request does not select keep their state.
- R7: When a request completes, its command field reads 0, and the select bits read back as they were written.
- R8: While sampling is off, a request stays pending (its command field reads the written code) and no rail changes. Once sampling is turned on, the timing of R5 runs from the edge that completes the enable write.
- R9: A write to a request word whose command is not idle is ignored. The two groups accept requests independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, 0 when not selected |
| rail_dpd | output | 64 | Per-rail power-down state, two groups of 32 |

## Verification
A table of requests is applied in turn. It alternates groups and directions and uses intervals of 1 to 5 cycles. Each request selects a different mix of rails: a few low bits, the top and bottom bits of a group, and all 30 bits. This tells apart a set operation from a clear operation, a mixed-up group, and an off-by-one in the delay, because the outputs are sampled on both sides of the expected edge. Directed cases then try an interval of 0, the reserved command, a request posted while sampling is off, and a second write aimed at a group that is still busy.

// File: rtl/iorail_dpd_ctrl.sv
module iorail_dpd_ctrl #(
  parameter int TMR_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [63:0]       rail_dpd
);
  localparam int NGRP = 2;
  localparam int NSEL = 30;
  localparam logic [ADDR_W-1:0] A_SAMP = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_TMR  = ADDR_W'(12'h1C8);

  logic              wr;
  logic              en_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [NSEL-1:0]   sel_q  [NGRP];
  logic [1:0]        code_q [NGRP];
  logic [NSEL-1:0]   st_q   [NGRP];
  logic [TMR_W-1:0]  cnt_q  [NGRP];
  logic [NGRP-1:0]   run_q;
  logic [NGRP-1:0]   wr_req;
  logic [TMR_W-1:0]  load_val;
  logic [31:0]       rd_mux;

  assign wr       = psel & penable & pwrite;
  assign load_val = (tmr_q == '0) ? TMR_W'(1) : tmr_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en_q  <= 1'b0;
      tmr_q <= '0;
    end else if (wr) begin
      if (paddr == A_SAMP) en_q  <= pwdata[0];
      if (paddr == A_TMR)  tmr_q <= pwdata[TMR_W-1:0];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(12'h1B8 + 8 * g);

    assign wr_req[g] = wr && (paddr == A_REQ);

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        sel_q[g]  <= '0;
        code_q[g] <= 2'd0;
        st_q[g]   <= '0;
        cnt_q[g]  <= '0;
        run_q[g]  <= 1'b0;
      end else if (wr_req[g] && code_q[g] == 2'd0) begin
        sel_q[g]  <= pwdata[NSEL-1:0];
        code_q[g] <= (pwdata[31:30] == 2'd3) ? 2'd0 : pwdata[31:30];
      end else if (en_q) begin
        if (!run_q[g] && code_q[g] != 2'd0) begin
          run_q[g] <= 1'b1;
          cnt_q[g] <= load_val;
        end else if (run_q[g]) begin
          if (cnt_q[g] == TMR_W'(1)) begin
            st_q[g]   <= (code_q[g] == 2'd2) ? (st_q[g] | sel_q[g])
                                             : (st_q[g] & ~sel_q[g]);
            run_q[g]  <= 1'b0;
            code_q[g] <= 2'd0;
          end else begin
            cnt_q[g] <= cnt_q[g] - TMR_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    case (paddr)
      A_SAMP:            rd_mux = {31'd0, en_q};
      A_TMR:             rd_mux = 32'(tmr_q);
      ADDR_W'(12'h1B8):  rd_mux = {code_q[0], sel_q[0]};
      ADDR_W'(12'h1BC):  rd_mux = {2'b00, st_q[0]};
      ADDR_W'(12'h1C0):  rd_mux = {code_q[1], sel_q[1]};
      ADDR_W'(12'h1C4):  rd_mux = {2'b00, st_q[1]};
      default:           rd_mux = 32'd0;
    endcase
  end

  assign prdata   = psel ? rd_mux : 32'd0;
  assign rail_dpd = {2'b00, st_q[1], 2'b00, st_q[0]};
endmodule

module iorail_dpd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] rail,
  input logic        en,
  input logic [1:0]  run,
  input logic [1:0]  code0,
  input logic [29:0] sel0,
  input logic        wr0
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> rail == 64'd0);
  a_r4_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rail[31:30] == 2'b00 && rail[63:62] == 2'b00);
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rail));
  a_r5_change_needs_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    run == 2'b00 |=> $stable(rail));
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run[0]) |-> code0 == 2'd0);
  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && code0 != 2'd0) |=> $stable(sel0));
endmodule

bind iorail_dpd_ctrl iorail_dpd_chk chk_i (
  .clk   (pclk),
  .rst_n (presetn),
  .rail  (rail_dpd),
  .en    (en_q),
  .run   (run_q),
  .code0 (code_q[0]),
  .sel0  (sel_q[0]),
  .wr0   (wr_req[0])
);

// File: tb/iorail_dpd_ctrl_tb.sv
`timescale 1ns/1ps
module iorail_dpd_ctrl_tb_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [63:0] rail_dpd;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_r;
  logic [31:0] rd;

  iorail_dpd_ctrl dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rail_dpd(rail_dpd)
  );

  always #4 pclk = ~pclk;

  localparam int NV = 5;
  localparam logic [31:0] VW [NV] = '{32'h8000_000F, 32'hB000_0001, 32'h4000_0005,
                                      32'hBFFF_FFFF, 32'h6000_0000};
  localparam int          VG [NV] = '{0, 1, 0, 0, 1};
  localparam int          VT [NV] = '{1, 3, 2, 5, 4};
  localparam logic [63:0] VE [NV] = '{64'h0000_0000_0000_000F, 64'h3000_0001_0000_000F,
                                      64'h3000_0001_0000_000A, 64'h3000_0001_3FFF_FFFF,
                                      64'h1000_0001_3FFF_FFFF};

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #1;
    d = prdata;
    psel = 1'b0;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge pclk);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitn(3);
    presetn = 1'b1;
    waitn(1);
    chk(rail_dpd == 64'd0, "R1 rails after reset", rail_dpd, 64'd0);
    peek(12'h020, rd); chk(rd == 0, "R1 sample reg after reset", 64'(rd), 64'd0);
    peek(12'h1C8, rd); chk(rd == 0, "R1 timer after reset", 64'(rd), 64'd0);
    peek(12'h1B8, rd); chk(rd == 0, "R1 request after reset", 64'(rd), 64'd0);
    peek(12'h1C4, rd); chk(rd == 0, "R1 state after reset", 64'(rd), 64'd0);

    wr(12'h1C8, 32'd7);
    peek(12'h1C8, rd); chk(rd == 7, "R2 timer readback", 64'(rd), 64'd7);
    wr(12'h020, 32'd1);
    peek(12'h020, rd); chk(rd == 1, "R2 sample enable readback", 64'(rd), 64'd1);

    exp_r = 64'd0;
    for (int v = 0; v < NV; v++) begin
      logic [11:0] ra;
      ra = (VG[v] == 0) ? 12'h1B8 : 12'h1C0;
      wr(12'h1C8, 32'(VT[v]));
      wr(ra, VW[v]);
      waitn(VT[v]);
      chk(rail_dpd == exp_r, "R5 rails before interval ends", rail_dpd, exp_r);
      waitn(1);
      chk(rail_dpd == VE[v], "R6 R3 rails after request", rail_dpd, VE[v]);
      exp_r = VE[v];
      peek(ra, rd);
      chk(rd == {2'b00, VW[v][29:0]}, "R7 command idle, select kept", 64'(rd),
          64'({2'b00, VW[v][29:0]}));
      peek(ra + 12'h4, rd);
      chk(rd == ((VG[v] == 0) ? {2'b00, VE[v][29:0]} : {2'b00, VE[v][61:32]}),
          "R4 state word", 64'(rd),
          64'((VG[v] == 0) ? {2'b00, VE[v][29:0]} : {2'b00, VE[v][61:32]}));
    end

    wr(12'h1C8, 32'd0);
    wr(12'h1B8, 32'h4000_0001);
    waitn(1);
    chk(rail_dpd == exp_r, "R5 zero interval early", rail_dpd, exp_r);
    waitn(1);
    exp_r = 64'h1000_0001_3FFF_FFFE;
    chk(rail_dpd == exp_r, "R5 zero interval acts as one", rail_dpd, exp_r);

    wr(12'h1B8, 32'hC000_0002);
    peek(12'h1B8, rd);
    chk(rd == 32'h0000_0002, "R3 reserved command reads idle", 64'(rd), 64'h2);
    waitn(10);
    chk(rail_dpd == exp_r, "R3 reserved command no effect", rail_dpd, exp_r);

    wr(12'h020, 32'd0);
    wr(12'h1C8, 32'd2);
    wr(12'h1C0, 32'h8000_0004);
    waitn(20);
    chk(rail_dpd == exp_r, "R8 no action while sampling off", rail_dpd, exp_r);
    peek(12'h1C0, rd);
    chk(rd == 32'h8000_0004, "R8 request pending", 64'(rd), 64'h8000_0004);
    wr(12'h020, 32'd1);
    waitn(2);
    chk(rail_dpd == exp_r, "R8 before interval after enable", rail_dpd, exp_r);
    waitn(1);
    exp_r = 64'h1000_0005_3FFF_FFFE;
    chk(rail_dpd == exp_r, "R8 action after enable", rail_dpd, exp_r);

    wr(12'h1C8, 32'd4);
    wr(12'h1B8, 32'h4000_0100);
    wr(12'h1B8, 32'h8000_0100);
    wr(12'h1C0, 32'h8000_0008);
    waitn(15);
    exp_r = 64'h1000_000D_3FFF_FEFE;
    chk(rail_dpd == exp_r, "R9 busy write ignored, other group accepted", rail_dpd, exp_r);
    peek(12'h1B8, rd);
    chk(rd == 32'h0000_0100, "R9 select unchanged by busy write", 64'(rd), 64'h100);
    chk(rail_dpd[31:30] == 2'b00 && rail_dpd[63:62] == 2'b00, "R4 spare outputs zero",
        64'({rail_dpd[63:62], rail_dpd[31:30]}), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule